// File: doc/BRIEF.md
# Cell Request Transfer Interface

This block moves fixed-size cells out of a fabric-side transmit buffer and into a core over a 40-bit bus that carries five octets per clock. The core paces the traffic with a one-cycle request strobe that it repeats at an interval matching the configured cell size. On the cycle after a request is accepted, the block sends one whole cell as a burst of consecutive beats and raises a cell-valid qualifier for every beat.

A slot is used only if the block is idle, the buffer holds a complete cell, and the core is not applying backpressure. Otherwise the slot is dropped and nothing is sent. Backpressure has no effect on a cell that has already started. A one-bit size select chooses between a short cell and a long cell, and the block samples it only when a cell starts. Any octets that the cell does not fill on its last beat go out as zeros. The buffer is read show-ahead: the current word is on the data input, and the block's read strobe consumes it.

Top module: `cell_req_xfer`

## Requirements
- R1: A cell starts only when, on the previous rising edge, the request was high, the buffer-empty flag was low, backpressure was low and no cell was in progress. The first beat then appears on the outputs during the next cycle. Octet 0 of a beat occupies bits [39:32], and each following octet sits in the next lower eight bits.
- R2: When size select is 0, a cell is exactly 16 consecutive valid beats carrying 79 octets by default.
- R3: When size select is 1, a cell is exactly 20 consecutive valid beats carrying 97 octets by default.
- R4: On the last beat of a cell, every octet position past the cell's final octet is zero. By default that is bits [7:0] for a short cell and bits [23:0] for a long cell. All other octets pass through unchanged.
- R5: A request that arrives while the buffer-empty flag is high is dropped. Valid and read stay low and no later cell is triggered by it.
- R6: A request that arrives while backpressure is high is dropped. No cell begins.
- R7: Backpressure raised while a cell is being sent has no effect. The cell completes all of its beats without a gap.
- R8: Changing size select while a cell is being sent does not change that cell's length.
- R9: A request that arrives while a cell is being sent is ignored. Valid falls after the running cell's last beat.
- R10: After reset, and whenever valid is low, the data output is all zeros and read enable is low.
- R11: Read enable is high on exactly the beats where valid is high, so each beat consumes one buffer word and the beats carry consecutive words in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_req_i | input | 1 | One-cycle cell request strobe from the core |
| core_bp_i | input | 1 | Backpressure from the core; blocks new cells |
| size_long_i | input | 1 | Cell size select: 0 = short (16 beats), 1 = long (20 beats) |
| buf_data_i | input | 40 | Show-ahead word from the transmit buffer |
| buf_empty_i | input | 1 | High when the buffer holds no complete cell |
| cell_data_o | output | 40 | Beat data to the core, zero-padded on the last beat |
| cell_valid_o | output | 1 | Qualifies each beat of a cell |
| buf_rd_o | output | 1 | Consumes the current buffer word |

## Verification
The only register between a request and its result is the state flop. A request sampled on one rising edge therefore shows its first beat, or its absence, during the very next cycle. Beat k of the cell is visible k cycles after that. The fall of valid comes one cycle after the last beat. The bench changes inputs on falling edges and reads the outputs on the falling edge that follows each rising edge. It checks beat 0 right after the request edge and then one beat per falling edge. It checks for a quiet bus on the falling edge after the final beat, and for skipped slots on the falling edge after the refused request. Expected words come from a bench counter that advances on every sampled read.

// File: rtl/cxf_pkg.sv
package cxf_pkg;
  localparam int OCTET_W         = 8;
  localparam int OCTETS_PER_BEAT = 5;
  localparam int BEAT_W          = OCTET_W * OCTETS_PER_BEAT;

  // octets carried by the last beat of a cell of cell_octets over beats
  function automatic int last_octets(input int cell_octets, input int beats);
    return cell_octets - OCTETS_PER_BEAT * (beats - 1);
  endfunction

  // zero-filled octets on the last beat
  function automatic int pad_octets(input int cell_octets, input int beats);
    return OCTETS_PER_BEAT * beats - cell_octets;
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/cxf_slot_gate.sv
module cxf_slot_gate (
  input  logic req_i,
  input  logic bp_i,
  input  logic empty_i,
  input  logic busy_i,
  output logic start_o
);
  // a slot is taken only when idle, data is ready and the core is not holding off
  assign start_o = req_i && !bp_i && !empty_i && !busy_i;
endmodule

// File: rtl/cxf_beat_seq.sv
module cxf_beat_seq #(
  parameter int SHORT_BEATS = 16,
  parameter int LONG_BEATS  = 20,
  parameter int CNT_W       = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic size_long_i,
  output logic busy_o,
  output logic size_q_o,
  output logic last_o
);
  localparam logic [CNT_W-1:0] SHORT_END = CNT_W'(SHORT_BEATS - 1);
  localparam logic [CNT_W-1:0] LONG_END  = CNT_W'(LONG_BEATS - 1);

  logic [CNT_W-1:0] beat_q;

  assign last_o = busy_o && (beat_q == (size_q_o ? LONG_END : SHORT_END));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o   <= 1'b0;
      size_q_o <= 1'b0;
      beat_q   <= '0;
    end else if (start_i) begin
      busy_o   <= 1'b1;
      size_q_o <= size_long_i;
      beat_q   <= '0;
    end else if (busy_o) begin
      if (last_o) begin
        busy_o <= 1'b0;
        beat_q <= '0;
      end else begin
        beat_q <= beat_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cxf_octet_pad.sv
module cxf_octet_pad import cxf_pkg::*; #(
  parameter int SHORT_LAST = 4,
  parameter int LONG_LAST  = 2
) (
  input  logic [BEAT_W-1:0] data_i,
  input  logic              en_i,
  input  logic              last_i,
  input  logic              size_long_i,
  output logic [BEAT_W-1:0] data_o
);
  for (genvar i = 0; i < OCTETS_PER_BEAT; i++) begin : g_oct
    localparam int HI = BEAT_W - 1 - OCTET_W * i;
    localparam bit IN_SHORT = (i < SHORT_LAST);
    localparam bit IN_LONG  = (i < LONG_LAST);
    logic keep;
    assign keep = !last_i || (size_long_i ? IN_LONG : IN_SHORT);
    assign data_o[HI -: OCTET_W] = (en_i && keep) ? data_i[HI -: OCTET_W] : '0;
  end
endmodule

// File: rtl/cell_req_xfer.sv
module cell_req_xfer import cxf_pkg::*; #(
  parameter int SHORT_BEATS  = 16,
  parameter int LONG_BEATS   = 20,
  parameter int SHORT_OCTETS = 79,
  parameter int LONG_OCTETS  = 97
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cell_req_i,
  input  logic              core_bp_i,
  input  logic              size_long_i,
  input  logic [BEAT_W-1:0] buf_data_i,
  input  logic              buf_empty_i,
  output logic [BEAT_W-1:0] cell_data_o,
  output logic              cell_valid_o,
  output logic              buf_rd_o
);
  localparam int MAX_BEATS  = max_int(SHORT_BEATS, LONG_BEATS);
  localparam int CNT_W      = $clog2(MAX_BEATS + 1);
  localparam int SHORT_LAST = last_octets(SHORT_OCTETS, SHORT_BEATS);
  localparam int LONG_LAST  = last_octets(LONG_OCTETS, LONG_BEATS);

  // named internal events, observed by the checker
  logic start_evt;
  logic last_beat;
  logic busy;
  logic size_q;

  cxf_slot_gate u_gate (
    .req_i   (cell_req_i),
    .bp_i    (core_bp_i),
    .empty_i (buf_empty_i),
    .busy_i  (busy),
    .start_o (start_evt)
  );

  cxf_beat_seq #(
    .SHORT_BEATS (SHORT_BEATS),
    .LONG_BEATS  (LONG_BEATS),
    .CNT_W       (CNT_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_evt),
    .size_long_i (size_long_i),
    .busy_o      (busy),
    .size_q_o    (size_q),
    .last_o      (last_beat)
  );

  cxf_octet_pad #(
    .SHORT_LAST (SHORT_LAST),
    .LONG_LAST  (LONG_LAST)
  ) u_pad (
    .data_i      (buf_data_i),
    .en_i        (busy),
    .last_i      (last_beat),
    .size_long_i (size_q),
    .data_o      (cell_data_o)
  );

  assign cell_valid_o = busy;
  assign buf_rd_o     = busy;
endmodule

// File: rtl/cell_req_xfer_chk.sv
module cell_req_xfer_chk import cxf_pkg::*; #(
  parameter int SHORT_BEATS  = 16,
  parameter int LONG_BEATS   = 20,
  parameter int SHORT_OCTETS = 79,
  parameter int LONG_OCTETS  = 97
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cell_req_i,
  input logic              core_bp_i,
  input logic              size_long_i,
  input logic              buf_empty_i,
  input logic              start_evt,
  input logic              cell_valid_o,
  input logic              buf_rd_o,
  input logic [BEAT_W-1:0] cell_data_o
);
  function automatic logic [BEAT_W-1:0] low_mask(input int pads);
    logic [BEAT_W-1:0] m;
    m = '0;
    for (int i = 0; i < OCTETS_PER_BEAT; i++)
      if (i < pads) m[OCTET_W*i +: OCTET_W] = '1;
    return m;
  endfunction

  localparam logic [BEAT_W-1:0] SHORT_MASK = low_mask(pad_octets(SHORT_OCTETS, SHORT_BEATS));
  localparam logic [BEAT_W-1:0] LONG_MASK  = low_mask(pad_octets(LONG_OCTETS, LONG_BEATS));

  logic [7:0] run;
  logic       size_c;
  logic [7:0] exp_len;

  assign exp_len = size_c ? 8'(LONG_BEATS) : 8'(SHORT_BEATS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run    <= '0;
      size_c <= 1'b0;
    end else begin
      run <= cell_valid_o ? run + 8'd1 : 8'd0;
      if (start_evt) size_c <= size_long_i;
    end
  end

  AST_START_NEEDS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cell_valid_o) |-> $past(cell_req_i && !core_bp_i && !buf_empty_i)); // R1
  AST_BURST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cell_valid_o) |-> (run == exp_len)); // R2, R3, R8
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    cell_valid_o |-> (run < exp_len)); // R9
  AST_PAD_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_valid_o && run == exp_len - 8'd1) |->
      ((cell_data_o & (size_c ? LONG_MASK : SHORT_MASK)) == '0)); // R4
  AST_EMPTY_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_req_i && buf_empty_i && !cell_valid_o) |=> !cell_valid_o); // R5
  AST_BP_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_req_i && core_bp_i && !cell_valid_o) |=> !cell_valid_o); // R6
  AST_BP_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_valid_o && run < exp_len - 8'd1) |=> cell_valid_o); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cell_valid_o |-> (cell_data_o == '0 && !buf_rd_o)); // R10
endmodule

bind cell_req_xfer cell_req_xfer_chk #(
  .SHORT_BEATS  (SHORT_BEATS),
  .LONG_BEATS   (LONG_BEATS),
  .SHORT_OCTETS (SHORT_OCTETS),
  .LONG_OCTETS  (LONG_OCTETS)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cell_req_i   (cell_req_i),
  .core_bp_i    (core_bp_i),
  .size_long_i  (size_long_i),
  .buf_empty_i  (buf_empty_i),
  .start_evt    (start_evt),
  .cell_valid_o (cell_valid_o),
  .buf_rd_o     (buf_rd_o),
  .cell_data_o  (cell_data_o)
);

// File: tb/sim_cell_req_xfer.sv
module sim_cell_req_xfer;
  localparam int SB = 16, LB = 20, SO = 79, LO = 97;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, bp = 1'b0, sel = 1'b0, empty = 1'b1;
  logic [39:0] bdata, dout;
  logic        valid, rd;
  logic [7:0]  wptr = 8'd0;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  // show-ahead buffer model: word content is a function of its index
  function automatic logic [39:0] word(input logic [7:0] p);
    return {p, p ^ 8'h5A, 8'h81, ~p, p | 8'h01};
  endfunction
  assign bdata = word(wptr);
  always @(posedge clk) if (rst_n && rd) wptr <= wptr + 8'd1;

  // expected beat: unused trailing octets of the last beat are zeros
  function automatic logic [39:0] expect_beat(input logic [7:0] p, input bit last, input int pads);
    logic [39:0] v;
    v = word(p);
    if (last) for (int i = 0; i < pads; i++) v[8*i +: 8] = 8'h00;
    return v;
  endfunction

  cell_req_xfer u0 (
    .clk(clk), .rst_n(rst_n), .cell_req_i(req), .core_bp_i(bp),
    .size_long_i(sel), .buf_data_i(bdata), .buf_empty_i(empty),
    .cell_data_o(dout), .cell_valid_o(valid), .buf_rd_o(rd)
  );

  task automatic chk(input bit ok, input string tag, input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic t_idle(input string tag);
    chk(valid == 1'b0, tag, {39'd0, valid}, 40'd0);
    chk(rd == 1'b0, tag, {39'd0, rd}, 40'd0);
    chk(dout == 40'd0, tag, dout, 40'd0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    t_idle("R10");
    rst_n = 1'b1;
    @(negedge clk);
    t_idle("R10");
  endtask

  // one cell; bp_mid raises backpressure inside, flip changes size select, req_mid re-requests
  task automatic t_cell(input bit lsel, input bit bp_mid, input bit flip, input bit req_mid, input string tag);
    int nb, pads;
    logic [7:0] p0;
    nb   = lsel ? LB : SB;
    pads = lsel ? (LB * 5 - LO) : (SB * 5 - SO);
    @(negedge clk);
    sel = lsel; empty = 1'b0; bp = 1'b0; req = 1'b1;
    p0 = wptr;
    @(negedge clk);
    req = 1'b0;
    for (int k = 0; k < nb; k++) begin
      logic [39:0] e;
      e = expect_beat(p0 + 8'(k), k == nb - 1, pads);
      chk(valid == 1'b1, (k == 0) ? "R1" : tag, {39'd0, valid}, 40'd1);
      chk(rd == 1'b1, "R11", {39'd0, rd}, 40'd1);
      chk(dout == e, (k == nb - 1) ? "R4" : "R1", dout, e);
      bp  = bp_mid && (k >= 1) && (k < nb - 1);
      req = req_mid && (k == 2);
      if (flip && k == 1) sel = ~lsel;
      @(negedge clk);
    end
    bp = 1'b0; req = 1'b0;
    chk(valid == 1'b0, tag, {39'd0, valid}, 40'd0);
    chk(wptr == p0 + 8'(nb), "R11", {32'd0, wptr}, {32'd0, p0 + 8'(nb)});
    t_idle("R10");
  endtask

  task automatic t_skip(input bit use_empty, input string tag);
    logic [7:0] p0;
    @(negedge clk);
    p0 = wptr;
    empty = use_empty; bp = !use_empty; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    t_idle(tag);
    @(negedge clk);
    empty = 1'b0; bp = 1'b0;
    @(negedge clk);
    t_idle(tag);
    chk(wptr == p0, tag, {32'd0, wptr}, {32'd0, p0});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_cell(1'b0, 1'b0, 1'b0, 1'b0, "R2");
    t_cell(1'b1, 1'b0, 1'b0, 1'b0, "R3");
    t_skip(1'b1, "R5");
    t_skip(1'b0, "R6");
    t_cell(1'b0, 1'b1, 1'b0, 1'b0, "R7");
    t_cell(1'b1, 1'b1, 1'b0, 1'b0, "R7");
    t_cell(1'b0, 1'b0, 1'b1, 1'b0, "R8");
    t_cell(1'b1, 1'b0, 1'b1, 1'b0, "R8");
    t_cell(1'b0, 1'b0, 1'b0, 1'b1, "R9");
    t_cell(1'b1, 1'b0, 1'b0, 1'b1, "R9");
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule